// File: doc/BRIEF.md
# Dual-Source PWM Prescaler Timebase

This block is the shared time reference for a group of PWM channels. It holds three independent timebase instances. Each one divides a selectable source tick through a 16-bit clock divider, then steps a 10-bit cycle counter once per divider wrap. The channels compare against the running cycle count and restart their waveform on a one-cycle period-start strobe. A period lasts `(D+1)*(C+1)` source ticks, where D is the divider value and C is the cycle-timer value.

Each instance picks its source tick from one of two enables. One is a fast system-clock enable. The other is a slow 32.768 kHz enable, which keeps running when the fast clock is stopped in low-power states. Software programs the block through a byte-wide write port. That port is a plain control path: every write strobe is taken in the cycle it appears, with no back-pressure and no read-back. New settings wait in shadow registers and reach the running counters only at a period boundary, so a running channel never sees a shortened period. A single global enable bit starts or freezes every counter at once.

Top module: `pwm_prescale_timebase`

## Requirements
- R1: After reset, every cycle count is 0, no period-start strobe is high, the global enable is off, and every instance has D=0, C=0 and the fast source selected.
- R2: While enabled, an instance's count steps by one every D+1 selected source ticks. It runs 0,1,…,C and then returns to 0, so one period is (D+1)*(C+1) source ticks.
- R3: For instance n (n=1,2,3), a write to address 4n sets D[7:0] and a write to address 4n+1 sets D[15:8].
- R4: A write to address 0x21+4n only holds data[1:0] as the pending upper two bits of C. A write to address 0x20+4n sets C to {held bits, data[7:0]}. A high-byte write by itself leaves C unchanged.
- R5: Bit 0 of the byte written to address 4n+2 selects the source: 1 selects the fast tick enable, 0 selects the slow tick enable. The divider restarts from zero when the new source takes over.
- R6: New D, C and source values take effect only when the current period ends. The period in progress keeps its old length.
- R7: Bit 1 of the byte written to address 0x70 is the global enable. While it is 0, every count holds its value and no strobe is produced.
- R8: `period_start[i]` is high for exactly the clock cycle in which `cycle_count[i]` has just returned to 0 at a period end. At every other time it is low.
- R9: Writes to any address outside the map above change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Fast source tick enable, one clock wide per tick |
| slow_tick | input | 1 | 32.768 kHz source tick enable, one clock wide per tick |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| cycle_count | output | 3x10 | Running cycle count of each instance, instance 1 in the low slot |
| period_start | output | 3 | Period-start strobe of each instance, instance 1 in bit 0 |

## Verification
The bench reprograms instances while their periods are running. A design that applied new values at once would produce a runt period, and this shows up as a wrong strobe interval. It writes a cycle-timer high byte on its own to catch a design that commits C on that write, and it writes a low byte to catch one that drops the held upper bits. It switches sources and clears the global enable with other bits of the byte set. A design that decodes the wrong bit, or lets counts creep while frozen, is caught because its counts and strobes diverge from the reference model in a given clock.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  localparam int PT_NINST  = 3;
  localparam int PT_DIV_W  = 16;
  localparam int PT_CT_W   = 10;
  localparam int PT_ADDR_W = 8;
  localparam int PT_DATA_W = 8;
  localparam int PT_STRIDE = 4;
  localparam logic [PT_ADDR_W-1:0] PT_CT_BASE = 8'h20;
  localparam logic [PT_ADDR_W-1:0] PT_GCTL    = 8'h70;
  localparam int PT_GEN_BIT = 1;
  localparam int PT_HI_W = PT_CT_W - PT_DATA_W;

  typedef struct packed {
    logic [PT_DIV_W-1:0] div;
    logic [PT_CT_W-1:0]  ct;
    logic                src_fast;
  } tb_cfg_t;

  localparam tb_cfg_t PT_CFG_RST = '{div: '0, ct: '0, src_fast: 1'b1};
endpackage

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
  import pwmtb_pkg::*;
#(
  parameter int NINST = PT_NINST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PT_ADDR_W-1:0] wr_addr,
  input  logic [PT_DATA_W-1:0] wr_data,
  output tb_cfg_t              cfg_o [NINST],
  output logic                 run_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) run_o <= 1'b0;
    else if (wr_en && wr_addr == PT_GCTL) run_o <= wr_data[PT_GEN_BIT];
  end

  for (genvar i = 0; i < NINST; i++) begin : g_inst
    localparam logic [PT_ADDR_W-1:0] A_DLO = PT_ADDR_W'(PT_STRIDE * (i + 1));
    localparam logic [PT_ADDR_W-1:0] A_DHI = A_DLO + 1'b1;
    localparam logic [PT_ADDR_W-1:0] A_SRC = A_DLO + 2'd2;
    localparam logic [PT_ADDR_W-1:0] A_CLO = PT_CT_BASE + A_DLO;
    localparam logic [PT_ADDR_W-1:0] A_CHI = A_CLO + 1'b1;

    tb_cfg_t            shadow;
    logic [PT_HI_W-1:0] ct_hold;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow  <= PT_CFG_RST;
        ct_hold <= '0;
      end else if (wr_en) begin
        unique case (wr_addr)
          A_DLO:   shadow.div[PT_DATA_W-1:0]        <= wr_data;
          A_DHI:   shadow.div[PT_DIV_W-1:PT_DATA_W] <= wr_data;
          A_SRC:   shadow.src_fast                  <= wr_data[0];
          A_CHI:   ct_hold                          <= wr_data[PT_HI_W-1:0];
          A_CLO:   shadow.ct                        <= {ct_hold, wr_data};
          default: ;
        endcase
      end
    end

    assign cfg_o[i] = shadow;
  end
endmodule

// File: rtl/pwmtb_engine.sv
module pwmtb_engine
  import pwmtb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               fast_tick,
  input  logic               slow_tick,
  input  tb_cfg_t            cfg,
  output logic [PT_CT_W-1:0] count_o,
  output logic               start_o
);
  tb_cfg_t             act;
  logic [PT_DIV_W-1:0] div_cnt;
  logic                tick, div_wrap, per_end;

  assign tick     = act.src_fast ? fast_tick : slow_tick;
  assign div_wrap = (div_cnt == act.div);
  assign per_end  = div_wrap && (count_o == act.ct);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= PT_CFG_RST;
      div_cnt <= '0;
      count_o <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (run && tick) begin
        if (!div_wrap) begin
          div_cnt <= div_cnt + 1'b1;
        end else begin
          div_cnt <= '0;
          if (per_end) begin
            count_o <= '0;
            start_o <= 1'b1;
            act     <= cfg;
          end else begin
            count_o <= count_o + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_prescale_timebase.sv
module pwm_prescale_timebase
  import pwmtb_pkg::*;
#(
  parameter int NINST = PT_NINST
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fast_tick,
  input  logic                            slow_tick,
  input  logic                            wr_en,
  input  logic [PT_ADDR_W-1:0]            wr_addr,
  input  logic [PT_DATA_W-1:0]            wr_data,
  output logic [NINST-1:0][PT_CT_W-1:0]   cycle_count,
  output logic [NINST-1:0]                period_start
);
  tb_cfg_t cfg [NINST];
  logic    run_en;

  pwmtb_regs #(.NINST(NINST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .run_o   (run_en)
  );

  for (genvar i = 0; i < NINST; i++) begin : g_eng
    pwmtb_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_en),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .cfg       (cfg[i]),
      .count_o   (cycle_count[i]),
      .start_o   (period_start[i])
    );
  end
endmodule

// File: rtl/pwmtb_chk.sv
module pwmtb_chk #(
  parameter int NINST = 3,
  parameter int CW    = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run_en,
  input logic [NINST-1:0][CW-1:0] cycle_count,
  input logic [NINST-1:0]         period_start
);
  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(cycle_count) && period_start == '0));

  for (genvar i = 0; i < NINST; i++) begin : g_chk
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cycle_count[i]) |->
        (cycle_count[i] == CW'($past(cycle_count[i]) + 1'b1) || cycle_count[i] == '0));
    // R8
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start[i] |-> cycle_count[i] == '0);
    // R8
    wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cycle_count[i]) && cycle_count[i] == '0) |-> period_start[i]);
  end
endmodule

bind pwm_prescale_timebase pwmtb_chk #(.NINST(NINST), .CW(pwmtb_pkg::PT_CT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .cycle_count  (cycle_count),
  .period_start (period_start)
);

// File: tb/sim_pwm_prescale_timebase.sv
`timescale 1ns/1ps
module sim_pwm_prescale_timebase;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_tick = 1'b0, slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [N-1:0][9:0] cycle_count;
  logic [N-1:0] period_start;

  int checks = 0, failures = 0, cyc = 0;
  bit fast_half = 1'b0, done = 1'b0;

  // reference model state
  int m_dsh[N], m_csh[N], m_hold[N], m_ssh[N];
  int m_da[N], m_ca[N], m_sa[N], m_dc[N], m_cnt[N];
  bit m_st[N];
  bit m_en;

  pwm_prescale_timebase u0 (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cycle_count(cycle_count), .period_start(period_start)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_en = 0;
      for (int i = 0; i < N; i++) begin
        m_dsh[i] = 0; m_csh[i] = 0; m_hold[i] = 0; m_ssh[i] = 1;
        m_da[i] = 0; m_ca[i] = 0; m_sa[i] = 1; m_dc[i] = 0; m_cnt[i] = 0; m_st[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit t;
        t = (m_sa[i] != 0) ? fast_tick : slow_tick;
        m_st[i] = 0;
        if (m_en && t) begin
          if (m_dc[i] < m_da[i]) m_dc[i]++;
          else begin
            m_dc[i] = 0;
            if (m_cnt[i] < m_ca[i]) m_cnt[i]++;
            else begin
              m_cnt[i] = 0; m_st[i] = 1;
              m_da[i] = m_dsh[i]; m_ca[i] = m_csh[i]; m_sa[i] = m_ssh[i];
            end
          end
        end
      end
      if (wr_en) begin
        if (wr_addr == 8'h70) m_en = wr_data[1];
        for (int n = 1; n <= N; n++) begin
          if (wr_addr == 4*n)          m_dsh[n-1] = (m_dsh[n-1] & 32'hFF00) | wr_data;
          if (wr_addr == 4*n + 1)      m_dsh[n-1] = (m_dsh[n-1] & 32'h00FF) | (wr_data << 8);
          if (wr_addr == 4*n + 2)      m_ssh[n-1] = wr_data[0];
          if (wr_addr == 8'h21 + 4*n)  m_hold[n-1] = wr_data & 3;
          if (wr_addr == 8'h20 + 4*n)  m_csh[n-1] = m_hold[n-1] * 256 + wr_data;
        end
      end
    end
  end

  // tick generators and per-cycle comparison
  always @(negedge clk) begin
    fast_tick <= fast_half ? (cyc % 2 == 0) : 1'b1;
    slow_tick <= (cyc % 5 == 0);
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        checks++;
        if (cycle_count[i] != m_cnt[i]) begin
          failures++;
          $display("FAIL R2 count inst%0d cyc %0d: actual %0d expected %0d", i+1, cyc, cycle_count[i], m_cnt[i]);
        end
        checks++;
        if (period_start[i] != m_st[i]) begin
          failures++;
          $display("FAIL R8 strobe inst%0d cyc %0d: actual %0d expected %0d", i+1, cyc, period_start[i], m_st[i]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start(input int i);
    int g = 0;
    do begin @(negedge clk); g++; end while (!period_start[i] && g < 5000);
  endtask

  task automatic period_of(input int i, output int len);
    int t0;
    wait_start(i);
    t0 = cyc;
    wait_start(i);
    len = cyc - t0;
  endtask

  initial begin
    int len, t0, strobes;
    logic [N-1:0][9:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 counts", int'(cycle_count), 0);
    chk("R1 strobes", int'(period_start), 0);

    // program while globally disabled
    wr(8'h04, 8'd2); wr(8'h25, 8'd0); wr(8'h24, 8'd5);   // inst1 D=2 C=5
    wr(8'h0A, 8'd0); wr(8'h28, 8'd3);                    // inst2 slow, C=3
    wr(8'h2D, 8'd1); wr(8'h2C, 8'd2);                    // inst3 C=258
    strobes = 0;
    repeat (20) begin @(negedge clk); strobes += $countones(period_start); end
    chk("R7 no strobe while disabled", strobes, 0);
    chk("R7 counts held while disabled", int'(cycle_count), 0);

    wr(8'h70, 8'h02);
    period_of(0, len); chk("R2 inst1 period D=2 C=5", len, 18);
    period_of(1, len); chk("R5 inst2 slow period", len, 20);
    period_of(2, len); chk("R4 inst3 period C=258", len, 259);

    // R3 divider high byte
    wr(8'h05, 8'd1);
    period_of(0, len); chk("R3 inst1 period D=0x102", len, 1554);

    // R6 mid-period update keeps the running period
    wait_start(0); t0 = cyc;
    repeat (10) @(negedge clk);
    wr(8'h05, 8'd0);
    wait_start(0); chk("R6 running period kept", cyc - t0, 1554);
    period_of(0, len); chk("R6 new period applied", len, 18);

    // R4 high byte alone has no effect, low byte commits
    wr(8'h2D, 8'd0);
    period_of(2, len); chk("R4 high byte alone", len, 259);
    wr(8'h2C, 8'd2);
    period_of(2, len); chk("R4 low byte commit", len, 3);

    // R9 unmapped writes ignored
    wr(8'h03, 8'hFF); wr(8'h31, 8'hFF); wr(8'h71, 8'hFF); wr(8'h10, 8'hFF);
    period_of(0, len); chk("R9 inst1 unaffected", len, 18);
    period_of(1, len); chk("R9 inst2 unaffected", len, 20);

    // R7 freeze with other bits set
    wr(8'h70, 8'hFD);
    snap = cycle_count; strobes = 0;
    repeat (20) begin @(negedge clk); strobes += $countones(period_start); end
    chk("R7 frozen counts", int'(cycle_count == snap), 1);
    chk("R7 frozen strobes", strobes, 0);
    wr(8'h70, 8'h02);

    // R5 back to fast source, then half-rate fast ticks
    wr(8'h0A, 8'h01);
    period_of(1, len); chk("R5 inst2 fast period", len, 4);
    fast_half = 1'b1;
    repeat (2) @(negedge clk);
    period_of(0, len); chk("R5 inst1 half-rate ticks", len, 36);
    period_of(1, len); chk("R5 inst2 half-rate ticks", len, 8);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule